// File: doc/BRIEF.md
# Round-Robin Multi-Bus Sector Interleaver

This block sits between a single host-side word stream and several narrow flash buses. It stripes whole sectors across the buses so that their combined bandwidth approaches the host rate. On the way out, sector k of the stream is routed in its entirety to bus k mod NUM_BUS. On the way back, sectors are taken from the buses in the same fixed rotation, which puts the returned data back into logical order no matter which bus delivers first.

Every bus has its own speed-matching FIFO in each direction. A slow or stalled bus therefore holds up only its own traffic until its FIFO fills, and the multiplexer can keep serving the other buses in the meantime. A read of a group of chips begins with a one-cycle command strobe to every bus at the same time. Each strobe also advances a chip-way selector, so that consecutive superpages alternate between chips on each bus and the read latency of one overlaps the transfer of the other.

Top module: `sid_interleaver`

## Requirements
- R1: After reset all FIFOs are empty: host_wr_ready is 1, host_rd_valid is 0, bus_tx_valid is all 0, bus_rx_ready is all 1, rd_cmd is 0 and rd_way is 0.
- R2: Words accepted on the host write port form sectors of SECTOR_BYTES/(DATA_W/8) words. Every word of sector k (counted from 0 since reset) leaves on bus k mod NUM_BUS, with word order kept. Bus i uses bits [i*DATA_W +: DATA_W] of the packed bus vectors.
- R3: While bus_tx_valid[i] is 1 and bus_tx_ready[i] is 0, bus i holds its valid and data. The other buses keep draining independently.
- R4: host_wr_ready is 0 exactly when the transmit FIFO of the bus that owns the current sector is full.
- R5: The host read port delivers sector k from bus k mod NUM_BUS, with words in the order that bus supplied them.
- R6: host_rd_valid is 0 whenever the receive FIFO of the bus in turn is empty, even if other buses hold data. No bus is ever skipped.
- R7: bus_rx_ready[i] is 0 only when receive FIFO i is full, and it does not depend on the state of any other bus.
- R8: A 1 on rd_start sets rd_cmd to all ones in the next cycle. In every other cycle rd_cmd is all zeros.
- R9: Each rd_start advances rd_way by one, wrapping from CHIP_WAYS-1 to 0. Otherwise rd_way holds.
- R10: While host_rd_valid is 1 and host_rd_ready is 0, host_rd_valid stays 1 and host_rd_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr_valid | input | 1 | Host write word valid |
| host_wr_data | input | DATA_W | Host write word |
| host_wr_ready | output | 1 | Host write word accepted |
| bus_tx_valid | output | NUM_BUS | Per-bus outgoing word valid |
| bus_tx_data | output | NUM_BUS*DATA_W | Per-bus outgoing words, packed |
| bus_tx_ready | input | NUM_BUS | Per-bus outgoing word taken |
| bus_rx_valid | input | NUM_BUS | Per-bus returned word valid |
| bus_rx_data | input | NUM_BUS*DATA_W | Per-bus returned words, packed |
| bus_rx_ready | output | NUM_BUS | Per-bus returned word accepted |
| host_rd_valid | output | 1 | Merged read word valid |
| host_rd_data | output | DATA_W | Merged read word in logical order |
| host_rd_ready | input | 1 | Host takes the merged word |
| rd_start | input | 1 | Request a read of the addressed chip group |
| rd_cmd | output | NUM_BUS | One-cycle read command strobe per bus |
| rd_way | output | max(1,clog2(CHIP_WAYS)) | Chip way addressed by the current read |

## Verification
The assertions check on every cycle the handshake hold rules on each bus and on the merged read port, the single-cycle shape of the command strobe, and the stepping of the chip-way selector. The sector-to-bus mapping, the reordering of sectors that arrive out of order, the refusal to skip an empty bus, and the isolation of a stalled bus until its FIFO fills all depend on multi-sector histories. Only the bench's scenarios show these, by feeding buses in reverse order and by holding one bus stalled while the others run.

// File: rtl/sid_pkg.sv
package sid_pkg;
  // Index width that never collapses to zero bits
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sid_fifo.sv
module sid_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int unsigned AW = sid_pkg::idx_w(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/sid_seq.sv
module sid_seq #(
  parameter int unsigned NUM_BUS = 4,
  parameter int unsigned WPS     = 128
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  step,
  output logic [sid_pkg::idx_w(NUM_BUS)-1:0]    bus_idx
);
  localparam int unsigned BW = sid_pkg::idx_w(NUM_BUS);
  localparam int unsigned CW = sid_pkg::idx_w(WPS);

  logic [BW-1:0] bus_q, bus_d;
  logic [CW-1:0] wcnt_q, wcnt_d;
  logic          last_word;

  assign bus_idx   = bus_q;
  assign last_word = (wcnt_q == CW'(WPS-1));

  always_comb begin
    bus_d  = bus_q;
    wcnt_d = wcnt_q;
    if (step) begin
      if (last_word) begin
        wcnt_d = '0;
        bus_d  = (bus_q == BW'(NUM_BUS-1)) ? '0 : bus_q + 1'b1;
      end else begin
        wcnt_d = wcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= '0;
      wcnt_q <= '0;
    end else begin
      bus_q  <= bus_d;
      wcnt_q <= wcnt_d;
    end
  end
endmodule

// File: rtl/sid_interleaver.sv
module sid_interleaver #(
  parameter int unsigned NUM_BUS      = 4,
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned SECTOR_BYTES = 512,
  parameter int unsigned FIFO_DEPTH   = 256,
  parameter int unsigned CHIP_WAYS    = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 host_wr_valid,
  input  logic [DATA_W-1:0]                    host_wr_data,
  output logic                                 host_wr_ready,
  output logic [NUM_BUS-1:0]                   bus_tx_valid,
  output logic [NUM_BUS*DATA_W-1:0]            bus_tx_data,
  input  logic [NUM_BUS-1:0]                   bus_tx_ready,
  input  logic [NUM_BUS-1:0]                   bus_rx_valid,
  input  logic [NUM_BUS*DATA_W-1:0]            bus_rx_data,
  output logic [NUM_BUS-1:0]                   bus_rx_ready,
  output logic                                 host_rd_valid,
  output logic [DATA_W-1:0]                    host_rd_data,
  input  logic                                 host_rd_ready,
  input  logic                                 rd_start,
  output logic [NUM_BUS-1:0]                   rd_cmd,
  output logic [sid_pkg::idx_w(CHIP_WAYS)-1:0] rd_way
);
  localparam int unsigned WPS = SECTOR_BYTES / (DATA_W / 8);
  localparam int unsigned BW  = sid_pkg::idx_w(NUM_BUS);
  localparam int unsigned WW  = sid_pkg::idx_w(CHIP_WAYS);

  // Asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  // Write direction: split
  logic [BW-1:0]      wr_bus;
  logic [NUM_BUS-1:0] tx_full, tx_empty, tx_push;
  logic               wr_fire;

  assign host_wr_ready = !tx_full[wr_bus];
  assign wr_fire       = host_wr_valid && host_wr_ready;

  sid_seq #(.NUM_BUS(NUM_BUS), .WPS(WPS)) u_wr_seq (
    .clk(clk), .rst_n(rst_q), .step(wr_fire), .bus_idx(wr_bus)
  );

  // Read direction: merge
  logic [BW-1:0]      rd_bus;
  logic [NUM_BUS-1:0] rx_full, rx_empty, rx_pop;
  logic [DATA_W-1:0]  rx_dout [NUM_BUS];
  logic               rd_fire;

  assign host_rd_valid = !rx_empty[rd_bus];
  assign host_rd_data  = rx_dout[rd_bus];
  assign rd_fire       = host_rd_valid && host_rd_ready;

  sid_seq #(.NUM_BUS(NUM_BUS), .WPS(WPS)) u_rd_seq (
    .clk(clk), .rst_n(rst_q), .step(rd_fire), .bus_idx(rd_bus)
  );

  for (genvar i = 0; i < NUM_BUS; i++) begin : g_bus
    assign tx_push[i]      = wr_fire && (wr_bus == BW'(i));
    assign bus_tx_valid[i] = !tx_empty[i];
    assign bus_rx_ready[i] = !rx_full[i];
    assign rx_pop[i]       = rd_fire && (rd_bus == BW'(i));

    sid_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx (
      .clk(clk), .rst_n(rst_q),
      .push(tx_push[i]), .din(host_wr_data), .full(tx_full[i]),
      .pop(bus_tx_ready[i]), .dout(bus_tx_data[i*DATA_W +: DATA_W]),
      .empty(tx_empty[i])
    );

    sid_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx (
      .clk(clk), .rst_n(rst_q),
      .push(bus_rx_valid[i]), .din(bus_rx_data[i*DATA_W +: DATA_W]),
      .full(rx_full[i]),
      .pop(rx_pop[i]), .dout(rx_dout[i]), .empty(rx_empty[i])
    );
  end

  // Group read command strobe and chip-way rotation
  logic [NUM_BUS-1:0] cmd_q, cmd_d;
  logic [WW-1:0]      way_q, way_d;

  always_comb begin
    cmd_d = rd_start ? '1 : '0;
    way_d = way_q;
    if (rd_start) way_d = (way_q == WW'(CHIP_WAYS-1)) ? '0 : way_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cmd_q <= '0;
      way_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      way_q <= way_d;
    end
  end

  assign rd_cmd = cmd_q;
  assign rd_way = way_q;
endmodule

// File: rtl/sid_checker.sv
module sid_checker #(
  parameter int unsigned NUM_BUS   = 4,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CHIP_WAYS = 2
) (
  input logic                                 clk,
  input logic                                 rst_q,
  input logic [NUM_BUS-1:0]                   bus_tx_valid,
  input logic [NUM_BUS*DATA_W-1:0]            bus_tx_data,
  input logic [NUM_BUS-1:0]                   bus_tx_ready,
  input logic                                 host_rd_valid,
  input logic [DATA_W-1:0]                    host_rd_data,
  input logic                                 host_rd_ready,
  input logic                                 rd_start,
  input logic [NUM_BUS-1:0]                   rd_cmd,
  input logic [sid_pkg::idx_w(CHIP_WAYS)-1:0] rd_way
);
  localparam int unsigned WW = sid_pkg::idx_w(CHIP_WAYS);

  AST_CMD_STROBE: assert property (@(posedge clk) disable iff (!rst_q)
    rd_start |=> (rd_cmd == '1));  // R8
  AST_CMD_QUIET: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_start |=> (rd_cmd == '0));  // R8
  AST_WAY_STEP: assert property (@(posedge clk) disable iff (!rst_q)
    rd_start |=> (rd_way == (($past(rd_way) == WW'(CHIP_WAYS-1)) ? '0 : $past(rd_way) + 1'b1)));  // R9
  AST_WAY_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_start |=> $stable(rd_way));  // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (host_rd_valid && !host_rd_ready) |=> (host_rd_valid && $stable(host_rd_data)));  // R10

  for (genvar i = 0; i < NUM_BUS; i++) begin : g_tx
    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
      (bus_tx_valid[i] && !bus_tx_ready[i]) |=>
        (bus_tx_valid[i] && $stable(bus_tx_data[i*DATA_W +: DATA_W])));  // R3
  end
endmodule

bind sid_interleaver sid_checker #(
  .NUM_BUS(NUM_BUS), .DATA_W(DATA_W), .CHIP_WAYS(CHIP_WAYS)
) u_chk (
  .clk(clk), .rst_q(rst_q),
  .bus_tx_valid(bus_tx_valid), .bus_tx_data(bus_tx_data), .bus_tx_ready(bus_tx_ready),
  .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data), .host_rd_ready(host_rd_ready),
  .rd_start(rd_start), .rd_cmd(rd_cmd), .rd_way(rd_way)
);

// File: tb/sim_sid_interleaver.sv
module sim_sid_interleaver;
  localparam int NB  = 4;
  localparam int DW  = 32;
  localparam int SB  = 16;
  localparam int WPS = SB / (DW / 8);
  localparam int FD  = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic host_wr_valid = 0;
  logic [DW-1:0] host_wr_data = '0;
  logic host_wr_ready;
  logic [NB-1:0] bus_tx_valid;
  logic [NB*DW-1:0] bus_tx_data;
  logic [NB-1:0] bus_tx_ready = '1;
  logic [NB-1:0] bus_rx_valid = '0;
  logic [NB*DW-1:0] bus_rx_data = '0;
  logic [NB-1:0] bus_rx_ready;
  logic host_rd_valid;
  logic [DW-1:0] host_rd_data;
  logic host_rd_ready = 1;
  logic rd_start = 0;
  logic [NB-1:0] rd_cmd;
  logic [0:0] rd_way;

  always #10 clk = ~clk;

  sid_interleaver #(.NUM_BUS(NB), .DATA_W(DW), .SECTOR_BYTES(SB),
                    .FIFO_DEPTH(FD), .CHIP_WAYS(2)) u0 (.*);

  int vectors = 0;
  int fails = 0;
  int wr_idx = 0;
  bit live = 0;
  logic [DW-1:0] exp_tx [NB][$];
  logic [DW-1:0] exp_rd [$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitors: pop expected items as the design hands them out
  always @(negedge clk) begin
    if (live) begin
      for (int i = 0; i < NB; i++) begin
        if (bus_tx_valid[i] && bus_tx_ready[i]) begin
          if (exp_tx[i].size() == 0) chk($sformatf("R2 bus%0d unexpected word", i), bus_tx_data[i*DW +: DW], 64'hDEAD);
          else chk($sformatf("R2 bus%0d word", i), bus_tx_data[i*DW +: DW], exp_tx[i].pop_front());
        end
      end
      if (host_rd_valid && host_rd_ready) begin
        if (exp_rd.size() == 0) chk("R5 unexpected read word", host_rd_data, 64'hDEAD);
        else chk("R5 merged word order", host_rd_data, exp_rd.pop_front());
      end
    end
  end

  task automatic push_word(input logic [DW-1:0] d);
    int b;
    b = (wr_idx / WPS) % NB;
    exp_tx[b].push_back(d);
    wr_idx++;
    host_wr_data  = d;
    host_wr_valid = 1;
    do @(negedge clk); while (!host_wr_ready);
    @(posedge clk); #1;
    host_wr_valid = 0;
  endtask

  task automatic feed(input int b, input logic [DW-1:0] d);
    bus_rx_data[b*DW +: DW] = d;
    bus_rx_valid[b] = 1;
    do @(negedge clk); while (!bus_rx_ready[b]);
    @(posedge clk); #1;
    bus_rx_valid[b] = 0;
  endtask

  function automatic logic [DW-1:0] rd_val(input int s, input int w);
    return 32'hB000_0000 | (s << 8) | w;
  endfunction

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 host_wr_ready", host_wr_ready, 1);
    chk("R1 host_rd_valid", host_rd_valid, 0);
    chk("R1 bus_tx_valid", bus_tx_valid, 0);
    chk("R1 bus_rx_ready", bus_rx_ready, 4'hF);
    chk("R1 rd_cmd", rd_cmd, 0);
    chk("R1 rd_way", rd_way, 0);
    live = 1;
    @(posedge clk); #1;

    // R2: plain striping, all buses ready
    for (int k = 0; k < 16 * WPS; k++) push_word(32'hA000_0000 + k);
    repeat (20) @(negedge clk);
    for (int i = 0; i < NB; i++) chk("R2 all striped words seen", exp_tx[i].size(), 0);

    // R3/R4: stall bus 1 while others run
    @(posedge clk); #1;
    bus_tx_ready = 4'b1101;
    for (int k = 0; k < 9 * WPS; k++) push_word(32'hA100_0000 + k);
    repeat (10) @(negedge clk);
    chk("R3 only stalled bus holds data", bus_tx_valid, 4'b0010);
    @(posedge clk); #1;
    host_wr_data = 32'hA1FF_0000; host_wr_valid = 1;
    repeat (3) @(negedge clk);
    chk("R4 ready low on full target bus", host_wr_ready, 0);
    chk("R3 stalled bus still valid", bus_tx_valid[1], 1);
    @(posedge clk); #1;
    bus_tx_ready = '1;
    push_word(32'hA1FF_0000);
    for (int k = 1; k < WPS; k++) push_word(32'hA1FF_0000 + k);
    repeat (20) @(negedge clk);
    for (int i = 0; i < NB; i++) chk("R3 stalled bus drains in order", exp_tx[i].size(), 0);

    // R5/R6/R7: buses return data in reverse order
    @(posedge clk); #1;
    for (int s = 0; s < 2 * NB; s++)
      for (int w = 0; w < WPS; w++) exp_rd.push_back(rd_val(s, w));
    for (int b = NB - 1; b >= 1; b--) begin
      for (int r = 0; r < 2; r++)
        for (int w = 0; w < WPS; w++) feed(b, rd_val(r * NB + b, w));
      if (b == NB - 1) begin
        @(negedge clk);
        chk("R7 only full bus refuses", bus_rx_ready, 4'b0111);
        @(posedge clk); #1;
      end
    end
    @(negedge clk);
    chk("R6 no skip past empty bus", host_rd_valid, 0);
    @(posedge clk); #1;
    for (int r = 0; r < 2; r++)
      for (int w = 0; w < WPS; w++) feed(0, rd_val(r * NB, w));
    repeat (50) @(negedge clk);
    chk("R5 all merged words seen", exp_rd.size(), 0);

    // R10: hold under host back-pressure
    @(posedge clk); #1;
    host_rd_ready = 0;
    for (int w = 0; w < WPS; w++) exp_rd.push_back(rd_val(8, w));
    for (int w = 0; w < WPS; w++) feed(0, rd_val(8, w));
    repeat (2) @(negedge clk);
    held = host_rd_data;
    repeat (3) @(negedge clk);
    chk("R10 valid held", host_rd_valid, 1);
    chk("R10 data held", host_rd_data, held);
    chk("R10 held word is sector start", held, rd_val(8, 0));
    @(posedge clk); #1;
    host_rd_ready = 1;
    repeat (10) @(negedge clk);
    chk("R5 back-pressured sector merged", exp_rd.size(), 0);

    // R8/R9: command strobe and way rotation
    @(posedge clk); #1;
    rd_start = 1;
    @(posedge clk); #1;
    rd_start = 0;
    @(negedge clk);
    chk("R8 strobe all buses", rd_cmd, 4'hF);
    chk("R9 way advanced", rd_way, 1);
    @(negedge clk);
    chk("R8 strobe lasts one cycle", rd_cmd, 0);
    chk("R9 way holds", rd_way, 1);
    @(posedge clk); #1;
    rd_start = 1;
    @(posedge clk); #1;
    rd_start = 0;
    @(negedge clk);
    chk("R8 second strobe", rd_cmd, 4'hF);
    chk("R9 way wraps", rd_way, 0);

    repeat (5) @(posedge clk);
    summary();
  end
endmodule